// File: doc/BRIEF.md
# Atomic Scratch Register Bank

This block holds five scratch registers that software uses for flags, mailboxes and locks. Three of them are 64-bit words and two are single bits. Each register can be reached at a plain address, where it acts as ordinary read/write storage. It can also be reached at a second, atomic address. At the atomic address of a word, a write takes effect only while the word is zero. At the atomic address of a bit, a read returns the old bit and sets the bit if it was clear. That read is a test-and-set, so the bit can serve as a hardware lock.

The port is a single-cycle register access. The requester presents an enable, a write flag, a byte address and write data. Read data is combinational and belongs to the cycle of the read. Any state change caused by the access takes effect at the next rising clock edge, so consecutive accesses are serialized in clock order. Only word 0 and the two lock bits are cleared by reset. Words 1 and 2 keep their contents when reset is asserted.

Top module: `scratch_bank`

## Requirements
- R1: Words 0, 1 and 2 sit at byte addresses 0x00, 0x08 and 0x10. A write there stores all 64 data bits, and a read there returns the stored word.
- R2: A synchronous active-high reset clears word 0 and both lock bits to zero. Words 1 and 2 keep their contents through reset.
- R3: Word aliases sit at 0x40, 0x48 and 0x50 for words 0, 1 and 2. A write to an alias stores the data only if the word is currently zero; otherwise the word is left unchanged.
- R4: A read of a word alias returns the word's current value and does not change it.
- R5: Lock bits 0 and 1 sit at byte addresses 0x18 and 0x20. A write there stores write-data bit 0. A read there returns the bit in bit 0, with bits 63:1 reading as zero.
- R6: Lock aliases sit at 0x58 and 0x60. A read there returns the bit's value before the access and leaves the bit set to 1 after the clock edge.
- R7: A write to a lock alias acts as a plain write of write-data bit 0 to that bit.
- R8: Two back-to-back reads of a lock alias, starting with the bit clear, return 0 and then 1.
- R9: A misaligned address (low three bits not zero) or an unmapped aligned address reads as zero, and writes to it change no register.
- R10: While the access enable is low, no register changes and the read data is zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; state changes on the rising edge |
| rst | input | 1 | Synchronous active-high reset |
| acc_en | input | 1 | Access request for this cycle |
| acc_wr | input | 1 | 1 = write, 0 = read |
| acc_addr | input | 7 | Byte address within the bank |
| acc_wdata | input | 64 | Write data |
| acc_rdata | output | 64 | Read data for the current read access, zero otherwise |

## Verification
The two functions that meet in the same cycle are the read path and the test-and-set update. A lock-alias read must return the bit's value from before the clock edge that sets it. The bench provokes this by issuing lock-alias reads on consecutive cycles with the bit first cleared. It judges the result by requiring 0 on the first read and 1 on the second, and then by reading the bit back at its plain address. The bench also runs a full sweep over all 128 byte addresses, both reads and writes. After every write it reads back all five registers and compares them against an arithmetic model of the alias and decode rules.

// File: rtl/scratch_pkg.sv
package scratch_pkg;

    // Geometry of the bank
    localparam int DATA_W     = 64;
    localparam int N_WIDE     = 3;
    localparam int N_LOCK     = 2;
    localparam int N_REG      = N_WIDE + N_LOCK;
    localparam int STRIDE_B   = 8;
    localparam int ALIAS_SLOT = 8;

    // Derived widths
    localparam int OFS_W  = $clog2(STRIDE_B);
    localparam int SLOT_W = $clog2(ALIAS_SLOT + N_REG);
    localparam int ADDR_W = OFS_W + SLOT_W;
    localparam int IDX_W  = $clog2(N_REG);

    typedef enum logic [1:0] {
        SLOT_NONE   = 2'd0,
        SLOT_NORMAL = 2'd1,
        SLOT_ALIAS  = 2'd2
    } slot_kind_e;

    typedef struct packed {
        slot_kind_e       kind;
        logic [IDX_W-1:0] idx;
    } slot_t;

    // Per-register command produced by the decoder
    typedef struct packed {
        logic              rd;
        logic              wr;
        logic              alias_hit;
        logic [DATA_W-1:0] wdata;
    } reg_cmd_t;

    function automatic slot_t decode_addr(input logic [ADDR_W-1:0] a);
        slot_t             r;
        logic [SLOT_W-1:0] slot;
        r.kind = SLOT_NONE;
        r.idx  = '0;
        slot   = a[ADDR_W-1:OFS_W];
        if (a[OFS_W-1:0] == '0) begin
            if (slot < SLOT_W'(N_REG)) begin
                r.kind = SLOT_NORMAL;
                r.idx  = IDX_W'(slot);
            end else if (slot >= SLOT_W'(ALIAS_SLOT) &&
                         slot <  SLOT_W'(ALIAS_SLOT + N_REG)) begin
                r.kind = SLOT_ALIAS;
                r.idx  = IDX_W'(slot - SLOT_W'(ALIAS_SLOT));
            end
        end
        return r;
    endfunction

endpackage

// File: rtl/scratch_decode.sv
module scratch_decode
    import scratch_pkg::*;
(
    input  logic              acc_en,
    input  logic              acc_wr,
    input  logic [ADDR_W-1:0] acc_addr,
    input  logic [DATA_W-1:0] acc_wdata,
    output reg_cmd_t          cmd [N_REG],
    output logic              hit
);

    slot_t slot;

    assign slot = decode_addr(acc_addr);
    assign hit  = acc_en && (slot.kind != SLOT_NONE);

    for (genvar i = 0; i < N_REG; i++) begin : g_cmd
        logic sel;
        assign sel              = hit && (slot.idx == IDX_W'(i));
        assign cmd[i].rd        = sel && !acc_wr;
        assign cmd[i].wr        = sel && acc_wr;
        assign cmd[i].alias_hit = (slot.kind == SLOT_ALIAS);
        assign cmd[i].wdata     = acc_wdata;
    end

endmodule

// File: rtl/scratch_word.sv
module scratch_word
    import scratch_pkg::*;
#(
    parameter bit RESET_EN = 1'b0
) (
    input  logic              clk,
    input  logic              rst,
    input  reg_cmd_t          cmd,
    output logic [DATA_W-1:0] q
);

    logic take;

    // Alias writes are accepted only into an all-zero word
    assign take = cmd.wr && (!cmd.alias_hit || (q == '0));

    always_ff @(posedge clk) begin
        if (RESET_EN && rst) begin
            q <= '0;
        end else if (take) begin
            q <= cmd.wdata;
        end
    end

    a_r1_plain_store: assert property (@(posedge clk) disable iff (rst)
        (cmd.wr && !cmd.alias_hit) |=> (q == $past(cmd.wdata)));

    a_r3_alias_drop: assert property (@(posedge clk) disable iff (rst)
        (cmd.wr && cmd.alias_hit && (q != '0)) |=> $stable(q));

    a_r4_alias_read_quiet: assert property (@(posedge clk) disable iff (rst)
        (cmd.rd && !cmd.wr) |=> $stable(q));

    if (RESET_EN) begin : g_rst_chk
        a_r2_word_reset: assert property (@(posedge clk)
            rst |=> (q == '0));
    end

endmodule

// File: rtl/scratch_lock.sv
module scratch_lock
    import scratch_pkg::*;
(
    input  logic     clk,
    input  logic     rst,
    input  reg_cmd_t cmd,
    output logic     q
);

    logic unused_hi;
    assign unused_hi = ^cmd.wdata[DATA_W-1:1];

    always_ff @(posedge clk) begin
        if (rst) begin
            q <= 1'b0;
        end else if (cmd.wr) begin
            q <= cmd.wdata[0];
        end else if (cmd.rd && cmd.alias_hit) begin
            q <= 1'b1;
        end
    end

    a_r6_test_sets: assert property (@(posedge clk) disable iff (rst)
        (cmd.rd && cmd.alias_hit) |=> q);

    a_r7_bit_write: assert property (@(posedge clk) disable iff (rst)
        cmd.wr |=> (q == $past(cmd.wdata[0])));

    a_r5_plain_read_quiet: assert property (@(posedge clk) disable iff (rst)
        (cmd.rd && !cmd.alias_hit) |=> $stable(q));

    a_r2_lock_reset: assert property (@(posedge clk)
        rst |=> !q);

endmodule

// File: rtl/scratch_bank.sv
module scratch_bank
    import scratch_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              acc_en,
    input  logic              acc_wr,
    input  logic [6:0]        acc_addr,
    input  logic [63:0]       acc_wdata,
    output logic [63:0]       acc_rdata
);

    reg_cmd_t          cmd [N_REG];
    logic              hit;
    logic [DATA_W-1:0] word_q [N_WIDE];
    logic [N_LOCK-1:0] lock_q;
    logic [N_REG-1:0]  rd_sel;
    logic [N_LOCK-1:0] lock_rd;

    scratch_decode u_decode (
        .acc_en    (acc_en),
        .acc_wr    (acc_wr),
        .acc_addr  (acc_addr),
        .acc_wdata (acc_wdata),
        .cmd       (cmd),
        .hit       (hit)
    );

    for (genvar i = 0; i < N_WIDE; i++) begin : g_word
        scratch_word #(
            .RESET_EN (i == 0)
        ) u_word (
            .clk (clk),
            .rst (rst),
            .cmd (cmd[i]),
            .q   (word_q[i])
        );
        assign rd_sel[i] = cmd[i].rd;
    end

    for (genvar j = 0; j < N_LOCK; j++) begin : g_lock
        scratch_lock u_lock (
            .clk (clk),
            .rst (rst),
            .cmd (cmd[N_WIDE + j]),
            .q   (lock_q[j])
        );
        assign rd_sel[N_WIDE + j] = cmd[N_WIDE + j].rd;
        assign lock_rd[j]         = cmd[N_WIDE + j].rd;
    end

    // Read mux: value before this cycle's edge, zero when no read hits
    always_comb begin
        acc_rdata = '0;
        for (int i = 0; i < N_WIDE; i++) begin
            if (rd_sel[i]) acc_rdata = word_q[i];
        end
        for (int j = 0; j < N_LOCK; j++) begin
            if (rd_sel[N_WIDE + j]) acc_rdata = {{(DATA_W-1){1'b0}}, lock_q[j]};
        end
    end

    a_r9_one_target: assert property (@(posedge clk) disable iff (rst)
        $onehot0(rd_sel));

    a_r9_miss_reads_zero: assert property (@(posedge clk) disable iff (rst)
        (acc_en && !hit) |-> (acc_rdata == '0));

    a_r5_lock_upper_zero: assert property (@(posedge clk) disable iff (rst)
        (|lock_rd) |-> (acc_rdata[DATA_W-1:1] == '0));

    a_r10_idle_hold: assert property (@(posedge clk) disable iff (rst)
        !acc_en |=> ($stable(lock_q) && $stable(word_q[0])));

    a_r10_idle_zero: assert property (@(posedge clk) disable iff (rst)
        !acc_en |-> (acc_rdata == '0));

endmodule

// File: tb/scratch_bank_bench.sv
module scratch_bank_bench;

    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst;
    logic        acc_en;
    logic        acc_wr;
    logic [6:0]  acc_addr;
    logic [63:0] acc_wdata;
    logic [63:0] acc_rdata;

    int checks = 0;
    int fails  = 0;

    logic [63:0] m [5];

    always #(CLK_PERIOD/2) clk = ~clk;

    scratch_bank u_scratch_bank (
        .clk       (clk),
        .rst       (rst),
        .acc_en    (acc_en),
        .acc_wr    (acc_wr),
        .acc_addr  (acc_addr),
        .acc_wdata (acc_wdata),
        .acc_rdata (acc_rdata)
    );

    task automatic check(input string req, input logic [6:0] a,
                         input logic [63:0] got, input logic [63:0] exp);
        checks++;
        if (got !== exp) begin
            fails++;
            $display("FAIL %s addr=%h got=%h exp=%h", req, a, got, exp);
        end
    endtask

    // One access per cycle: drive at falling edge, sample before rising edge
    task automatic acc(input logic en, input logic wr, input logic [6:0] a,
                       input logic [63:0] d, output logic [63:0] rd);
        @(negedge clk);
        acc_en = en; acc_wr = wr; acc_addr = a; acc_wdata = d;
        #1;
        rd = acc_rdata;
        @(posedge clk);
        #1;
        acc_en = 1'b0; acc_wr = 1'b0;
    endtask

    function automatic logic [63:0] mval(input int i);
        return (i < 3) ? m[i] : {63'd0, m[i][0]};
    endfunction

    function automatic string tag_of(input int a);
        int s;
        s = a / 8;
        if ((a % 8) != 0 || (s >= 5 && s < 8) || s >= 13) return "R9";
        if (s < 3)  return "R1";
        if (s < 5)  return "R5";
        if (s < 11) return "R4";
        return "R6";
    endfunction

    task automatic model_read(input int a, output logic [63:0] r);
        int s;
        s = a / 8;
        r = '0;
        if ((a % 8) == 0) begin
            if (s < 5) r = mval(s);
            else if (s >= 8 && s < 13) begin
                r = mval(s - 8);
                if (s - 8 >= 3) m[s-8] = 64'd1;
            end
        end
    endtask

    task automatic model_write(input int a, input logic [63:0] d);
        int s, i;
        s = a / 8;
        if ((a % 8) == 0) begin
            if (s < 5) m[s] = (s < 3) ? d : {63'd0, d[0]};
            else if (s >= 8 && s < 13) begin
                i = s - 8;
                if (i < 3) begin
                    if (m[i] == 64'd0) m[i] = d;
                end else m[i] = {63'd0, d[0]};
            end
        end
    endtask

    task automatic read_all(input string req);
        logic [63:0] r;
        for (int i = 0; i < 5; i++) begin
            acc(1'b1, 1'b0, 7'(i * 8), '0, r);
            check(req, 7'(i * 8), r, mval(i));
        end
    endtask

    initial begin
        #(CLK_PERIOD * 200000);
        fails++;
        $display("FAIL watchdog expired");
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        logic [63:0] r;
        rst = 1'b1; acc_en = 1'b0; acc_wr = 1'b0; acc_addr = '0; acc_wdata = '0;
        repeat (3) @(posedge clk);
        #1 rst = 1'b0;

        // R2: reset state of word 0 and locks
        m[0] = '0; m[3] = '0; m[4] = '0;
        acc(1'b1, 1'b0, 7'h00, '0, r); check("R2", 7'h00, r, 64'd0);
        acc(1'b1, 1'b0, 7'h18, '0, r); check("R2", 7'h18, r, 64'd0);
        acc(1'b1, 1'b0, 7'h20, '0, r); check("R2", 7'h20, r, 64'd0);

        // R1: plain writes to all words
        for (int i = 0; i < 3; i++) begin
            logic [63:0] d;
            d = 64'hDEAD_BEEF_0000_0000 | 64'(i * 17 + 3);
            acc(1'b1, 1'b1, 7'(i * 8), d, r); model_write(i * 8, d);
        end
        read_all("R1");

        // R2: pulse reset, words 1 and 2 must survive
        @(negedge clk) rst = 1'b1;
        @(posedge clk); #1 rst = 1'b0;
        m[0] = '0; m[3] = '0; m[4] = '0;
        read_all("R2");

        // R3: alias write accepted into zero word, then dropped
        acc(1'b1, 1'b1, 7'h08, 64'd0, r); model_write(8, 64'd0);
        acc(1'b1, 1'b1, 7'h48, 64'h1111_2222_3333_4444, r); model_write(72, 64'h1111_2222_3333_4444);
        acc(1'b1, 1'b0, 7'h08, '0, r); check("R3", 7'h08, r, 64'h1111_2222_3333_4444);
        acc(1'b1, 1'b1, 7'h48, 64'h5555_6666_7777_8888, r); model_write(72, 64'h5555_6666_7777_8888);
        acc(1'b1, 1'b0, 7'h08, '0, r); check("R3", 7'h08, r, 64'h1111_2222_3333_4444);

        // R8: back-to-back test-and-set on a clear lock
        acc(1'b1, 1'b1, 7'h18, 64'd0, r); model_write(24, 64'd0);
        acc(1'b1, 1'b0, 7'h58, '0, r); check("R8", 7'h58, r, 64'd0); model_read(88, r);
        acc(1'b1, 1'b0, 7'h58, '0, r); check("R8", 7'h58, r, 64'd1); model_read(88, r);
        acc(1'b1, 1'b0, 7'h18, '0, r); check("R6", 7'h18, r, 64'd1);

        // R7: alias write clears the lock
        acc(1'b1, 1'b1, 7'h58, 64'hFFFF_FFFF_FFFF_FFFE, r); model_write(88, 64'hFFFF_FFFF_FFFF_FFFE);
        acc(1'b1, 1'b0, 7'h18, '0, r); check("R7", 7'h18, r, 64'd0);

        // R10: disabled writes change nothing and read zero
        for (int a = 0; a < 128; a += 8) begin
            acc(1'b0, 1'b1, 7'(a), 64'hABCD_0000_0000_0001, r);
            check("R10", 7'(a), r, 64'd0);
        end
        read_all("R10");

        // Sweep reads over the whole address space
        for (int a = 0; a < 128; a++) begin
            logic [63:0] e;
            acc(1'b1, 1'b0, 7'(a), '0, r);
            model_read(a, e);
            check(tag_of(a), 7'(a), r, e);
        end

        // Sweep writes over the whole address space, readback all registers
        for (int a = 0; a < 128; a++) begin
            logic [63:0] d;
            if (a == 64 || a == 72) begin
                acc(1'b1, 1'b1, 7'(a - 64), 64'd0, r); model_write(a - 64, 64'd0);
            end
            d = 64'hF00D_0000_0000_0000 | (64'(a) << 1) | 64'(a[3]);
            acc(1'b1, 1'b1, 7'(a), d, r);
            model_write(a, d);
            read_all((tag_of(a) == "R4") ? "R3" : (tag_of(a) == "R6") ? "R7" : tag_of(a));
        end

        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

endmodule